// File: doc/BRIEF.md
# PHY Control-Register Access Sequencer

This block is a hardware master for the control-register port of a PHY. A host hands it a 16-bit register address, 16 bits of write data, a read/write select and a one-cycle start pulse. The block then runs the request/acknowledge handshake that the port expects. It drives one shared 16-bit bus that carries the address and the data at different times, and four strobes: capture-address, capture-data, read and write. It returns the read data, a one-cycle done pulse and a one-cycle error pulse.

Each access is a fixed chain of full handshake phases. In every phase the block raises one strobe, waits for the acknowledge to rise, drops the strobe while holding the bus, and waits for the acknowledge to fall. Before a capture strobe rises, the value on the bus is held for a set number of cycles with all strobes low. The acknowledge input is re-timed through two flops. Each wait samples it at a fixed poll interval and gives up after a set number of polls. When a wait gives up, the access is abandoned, the strobes are released, any read result is zero, and the block becomes idle again.

Top module: `phy_creg_master`

## Requirements
- R1: After reset, `busy`, `done`, `err`, all four strobes, `phy_bus` and `rdata` are all 0.
- R2: Every access starts with an address phase. The address is on `phy_bus` when `phy_cap_addr` rises, and it stays there until the acknowledge has fallen again.
- R3: A write raises the strobes in the order capture-address, capture-data, write. The write data is on `phy_bus` throughout both the capture-data phase and the write phase.
- R4: A read raises capture-address and then `phy_rd`. `phy_bus` is 0 while `phy_rd` is high. `phy_rdata` is sampled when the acknowledge is seen high, and the sampled value is shown on `rdata` when `done` pulses.
- R5: Before `phy_cap_addr` or `phy_cap_data` rises, `phy_bus` holds the new value for at least `SETUP_CYCLES` cycles (2 or more) with all strobes low.
- R6: At most one strobe is high at any time. A strobe stays high until the acknowledge has been seen high. `phy_bus` does not change on the cycle a strobe falls.
- R7: Each acknowledge wait polls on its first cycle and then every `POLL_CYCLES` cycles. After `POLL_LIMIT` failed polls the access aborts. `err` pulses for one cycle, `rdata` becomes 0, all strobes go low and the block returns to idle. With the acknowledge never answering, `err` appears `SETUP_CYCLES + (POLL_LIMIT-1)*POLL_CYCLES + 2` cycles after the cycle in which `start` is driven.
- R8: `busy` is high from the cycle after an accepted start through the cycle of `done` or `err`, and low after that. `done` and `err` are single-cycle pulses and are never high together.
- R9: A `start` pulse while `busy` is high is ignored. It starts no later access and does not change the address or data of the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| write_en | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on handshake timeout |
| rdata | output | 16 | Read result, or 0 after an abort |
| phy_bus | output | 16 | Shared address/data bus to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write strobe |
| phy_ack | input | 1 | Acknowledge from the PHY, asynchronous |
| phy_rdata | input | 16 | Read data from the PHY, valid while acknowledge is high |

## Verification
The bench builds the block with `POLL_CYCLES=3`, `POLL_LIMIT=5` and `SETUP_CYCLES=2`. With these values a whole timeout window is only twelve cycles long. That makes both sides of the limit cheap to reach: an acknowledge six cycles late still passes, and one twenty cycles late aborts. It also brings into reach a PHY that never answers, and one that answers but never releases the acknowledge. Because the window is short, the exact abort cycle can be checked against the formula in R7.

// File: rtl/pcm_pkg.sv
// Package pcm_pkg
// Shared types for the PHY control-register access sequencer.
// Assumes: the strobe vector is indexed by the phase code.
package pcm_pkg;

    // Phase codes double as the index of the strobe that a phase drives.
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_DATA  = 2'd1,
        PH_READ  = 2'd2,
        PH_WRITE = 2'd3
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HI    = 3'd2,
        ST_LO    = 3'd3,
        ST_DONE  = 3'd4,
        ST_ERR   = 3'd5
    } state_t;

    localparam int NUM_STROBES = 4;

    // One-hot strobe pattern for a phase.
    function automatic logic [NUM_STROBES-1:0] strobe_of(input phase_t ph);
        logic [NUM_STROBES-1:0] v;
        v = '0;
        v[ph] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pcm_ack_sync.sv
// Module pcm_ack_sync
// Two-flop re-timer for the asynchronous acknowledge from the PHY.
// Assumes: the acknowledge is a level that stays put for several cycles.
module pcm_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_async,
    output logic ack_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw acknowledge through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ack_async};
        end
    end

    assign ack_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pcm_poll_timer.sv
// Module pcm_poll_timer
// Paces the acknowledge polls of one wait and counts the failed ones.
// Assumes: arm is high for one cycle on every entry into a wait state.
module pcm_poll_timer #(
    parameter int POLL_CYCLES = 1000,
    parameter int POLL_LIMIT  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    output logic poll_now,
    output logic poll_last
);

    localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam int CW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [TW-1:0] T_RELOAD = TW'(POLL_CYCLES - 1);
    localparam logic [CW-1:0] C_LAST   = CW'(POLL_LIMIT - 1);

    logic [TW-1:0] tmr_q;
    logic [CW-1:0] cnt_q;

    assign poll_now  = active && (tmr_q == '0);
    assign poll_last = (cnt_q == C_LAST);

    // Interval timer and failed-poll counter, cleared when a wait begins.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) begin
            tmr_q <= '0;
            cnt_q <= '0;
        end else if (poll_now) begin
            tmr_q <= T_RELOAD;
            if (cnt_q != C_LAST) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - TW'(1);
        end
    end

endmodule

// File: rtl/pcm_phase_fsm.sv
// Module pcm_phase_fsm
// Walks the chain of handshake phases for one access and owns the bus,
// the strobes and the result registers.
// Assumes: ack_s is already re-timed, and poll_now/poll_last come from a
// timer that is cleared by arm.
module pcm_phase_fsm
    import pcm_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SETUP_CYCLES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   write_en,
    input  logic [DATA_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W-1:0]      phy_rdata,
    input  logic                   ack_s,
    input  logic                   poll_now,
    input  logic                   poll_last,
    output logic                   arm,
    output logic                   waiting,
    output logic [DATA_W-1:0]      bus,
    output logic [NUM_STROBES-1:0] strobes,
    output logic [DATA_W-1:0]      rdata,
    output logic                   busy,
    output logic                   done,
    output logic                   err
);

    localparam int SW = (SETUP_CYCLES > 1) ? $clog2(SETUP_CYCLES) : 1;
    localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_CYCLES - 1);

    state_t                   state_q, state_d;
    phase_t                   phase_q, phase_d;
    logic [SW-1:0]            setup_q, setup_d;
    logic [DATA_W-1:0]        data_q, data_d;
    logic                     wr_q, wr_d;
    logic [DATA_W-1:0]        bus_q, bus_d;
    logic [NUM_STROBES-1:0]   strb_q, strb_d;
    logic [DATA_W-1:0]        rdata_q, rdata_d;

    // Next-state and next-output logic for the phase chain.
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        setup_d = setup_q;
        data_d  = data_q;
        wr_d    = wr_q;
        bus_d   = bus_q;
        strb_d  = strb_q;
        rdata_d = rdata_q;
        arm     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    data_d  = req_wdata;
                    wr_d    = write_en;
                    phase_d = PH_ADDR;
                    bus_d   = req_addr;
                    setup_d = '0;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (setup_q == SETUP_LAST) begin
                    strb_d  = strobe_of(phase_q);
                    state_d = ST_HI;
                    arm     = 1'b1;
                end else begin
                    setup_d = setup_q + SW'(1);
                end
            end
            ST_HI: begin
                if (poll_now) begin
                    if (ack_s) begin
                        strb_d  = '0;
                        state_d = ST_LO;
                        arm     = 1'b1;
                        if (phase_q == PH_READ) begin
                            rdata_d = phy_rdata;
                        end
                    end else if (poll_last) begin
                        strb_d  = '0;
                        rdata_d = '0;
                        state_d = ST_ERR;
                    end
                end
            end
            ST_LO: begin
                if (poll_now) begin
                    if (!ack_s) begin
                        case (phase_q)
                            PH_ADDR: begin
                                if (wr_q) begin
                                    phase_d = PH_DATA;
                                    bus_d   = data_q;
                                    setup_d = '0;
                                    state_d = ST_SETUP;
                                end else begin
                                    phase_d = PH_READ;
                                    bus_d   = '0;
                                    strb_d  = strobe_of(PH_READ);
                                    state_d = ST_HI;
                                    arm     = 1'b1;
                                end
                            end
                            PH_DATA: begin
                                phase_d = PH_WRITE;
                                strb_d  = strobe_of(PH_WRITE);
                                state_d = ST_HI;
                                arm     = 1'b1;
                            end
                            default: begin
                                state_d = ST_DONE;
                            end
                        endcase
                    end else if (poll_last) begin
                        strb_d  = '0;
                        rdata_d = '0;
                        state_d = ST_ERR;
                    end
                end
            end
            ST_DONE, ST_ERR: begin
                bus_d   = '0;
                state_d = ST_IDLE;
            end
            default: begin
                strb_d  = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR;
            setup_q <= '0;
            data_q  <= '0;
            wr_q    <= 1'b0;
            bus_q   <= '0;
            strb_q  <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            setup_q <= setup_d;
            data_q  <= data_d;
            wr_q    <= wr_d;
            bus_q   <= bus_d;
            strb_q  <= strb_d;
            rdata_q <= rdata_d;
        end
    end

    assign waiting = (state_q == ST_HI) || (state_q == ST_LO);
    assign bus     = bus_q;
    assign strobes = strb_q;
    assign rdata   = rdata_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign err     = (state_q == ST_ERR);

endmodule

// File: rtl/phy_creg_master.sv
// Module phy_creg_master
// Top level: turns a host read/write request into the multi-phase
// strobe/acknowledge exchange of a PHY control-register port.
// Assumes: phy_ack is asynchronous; phy_rdata is stable while ack is high.
module phy_creg_master
    import pcm_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int POLL_CYCLES  = 1000,
    parameter int POLL_LIMIT   = 200,
    parameter int SETUP_CYCLES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write_en,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] phy_bus,
    output logic              phy_cap_addr,
    output logic              phy_cap_data,
    output logic              phy_rd,
    output logic              phy_wr,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata
);

    logic                   ack_s;
    logic                   arm;
    logic                   waiting;
    logic                   poll_now;
    logic                   poll_last;
    logic [NUM_STROBES-1:0] strobes;

    pcm_ack_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_async(phy_ack),
        .ack_sync (ack_s)
    );

    pcm_poll_timer #(
        .POLL_CYCLES(POLL_CYCLES),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .active   (waiting),
        .poll_now (poll_now),
        .poll_last(poll_last)
    );

    pcm_phase_fsm #(
        .DATA_W      (DATA_W),
        .SETUP_CYCLES(SETUP_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .write_en (write_en),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .phy_rdata(phy_rdata),
        .ack_s    (ack_s),
        .poll_now (poll_now),
        .poll_last(poll_last),
        .arm      (arm),
        .waiting  (waiting),
        .bus      (phy_bus),
        .strobes  (strobes),
        .rdata    (rdata),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    assign phy_cap_addr = strobes[PH_ADDR];
    assign phy_cap_data = strobes[PH_DATA];
    assign phy_rd       = strobes[PH_READ];
    assign phy_wr       = strobes[PH_WRITE];

endmodule

// File: rtl/pcm_checker.sv
// Module pcm_checker
// Port-level properties of the access sequencer, bound to the top module.
// Assumes: observes ports only; reset is synchronous and active low.
module pcm_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] phy_bus,
    input logic              phy_cap_addr,
    input logic              phy_cap_data,
    input logic              phy_rd,
    input logic              phy_wr
);

    logic [3:0] stb;
    assign stb = {phy_wr, phy_rd, phy_cap_data, phy_cap_addr};

    // R5: the bus is steady with strobes low for two cycles before a capture strobe rises
    a_r5_setup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(phy_cap_addr) || $rose(phy_cap_data)) |->
            ($past(phy_bus) == phy_bus && $past(phy_bus, 2) == phy_bus &&
             $past(stb) == 4'b0 && $past(stb, 2) == 4'b0));

    // R6: never more than one strobe
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    // R6: the bus does not move on the cycle a strobe is released
    a_r6_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(phy_cap_addr) || $fell(phy_cap_data) || $fell(phy_rd) || $fell(phy_wr))
            |-> $stable(phy_bus));

    // R4: the bus is cleared while the read strobe is high
    a_r4_read_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rd |-> (phy_bus == '0));

    // R7: an abort shows zero read data and no strobes
    a_r7_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '0 && stb == 4'b0));

    // R8: done and err fall inside busy, never together, one cycle each
    a_r8_end_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> busy);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> !(done || err || busy));

endmodule

bind phy_creg_master pcm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .rdata       (rdata),
    .phy_bus     (phy_bus),
    .phy_cap_addr(phy_cap_addr),
    .phy_cap_data(phy_cap_data),
    .phy_rd      (phy_rd),
    .phy_wr      (phy_wr)
);

// File: tb/sim_phy_creg_master.sv
module sim_phy_creg_master;

    localparam int P_POLL  = 3;
    localparam int P_LIMIT = 5;
    localparam int P_SETUP = 2;
    localparam int TO_CYC  = P_SETUP + (P_LIMIT - 1) * P_POLL + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        write_en = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, err;
    logic [15:0] rdata, phy_bus;
    logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic        phy_ack;
    logic [15:0] phy_rdata;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    phy_creg_master #(
        .POLL_CYCLES (P_POLL),
        .POLL_LIMIT  (P_LIMIT),
        .SETUP_CYCLES(P_SETUP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .write_en(write_en),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .err(err), .rdata(rdata), .phy_bus(phy_bus), .phy_cap_addr(phy_cap_addr),
        .phy_cap_data(phy_cap_data), .phy_rd(phy_rd), .phy_wr(phy_wr),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // ---------------- PHY model: 0 normal, 1 never acks, 2 never releases
    int          ack_dly = 1;
    int          ack_mode = 0;
    int          dcnt;
    logic [15:0] lat_a;
    logic [15:0] mem [16];

    always @(posedge clk) begin
        if (!rst_n) begin
            phy_ack   <= 1'b0;
            phy_rdata <= '0;
            dcnt      <= 0;
            lat_a     <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= '0;
        end else if ((phy_cap_addr | phy_cap_data | phy_rd | phy_wr) && !phy_ack && ack_mode != 1) begin
            if (dcnt >= ack_dly) begin
                phy_ack <= 1'b1;
                dcnt    <= 0;
                if (phy_cap_addr) lat_a <= phy_bus;
                if (phy_wr) mem[lat_a[3:0]] <= phy_bus;
                if (phy_rd) phy_rdata <= mem[lat_a[3:0]];
            end else dcnt <= dcnt + 1;
        end else if (!(phy_cap_addr | phy_cap_data | phy_rd | phy_wr) && phy_ack && ack_mode != 2) begin
            if (dcnt >= ack_dly) begin
                phy_ack <= 1'b0;
                dcnt    <= 0;
            end else dcnt <= dcnt + 1;
        end else dcnt <= 0;
    end

    // ---------------- port monitor, sampled away from the active edge
    logic [3:0]  prev_stb = '0;
    logic [15:0] prev_bus = '0;
    int          quiet = 0;
    logic        ack_seen = 1'b0;
    logic [15:0] seq = '0;
    int          rises = 0;
    int          v_multi = 0, v_setup = 0, v_drop = 0, v_rdbus = 0, v_data = 0;
    logic [15:0] exp_data = '0;

    always @(negedge clk) begin
        logic [3:0] s;
        s = {phy_wr, phy_rd, phy_cap_data, phy_cap_addr};
        if (rst_n) begin
            if ($countones(s) > 1) v_multi++;
            if (s[0] && !prev_stb[0]) begin seq = {seq[11:0], 4'h1}; rises++; if (quiet < P_SETUP) v_setup++; end
            if (s[1] && !prev_stb[1]) begin seq = {seq[11:0], 4'h2}; rises++; if (quiet < P_SETUP) v_setup++; end
            if (s[2] && !prev_stb[2]) begin seq = {seq[11:0], 4'h4}; rises++; end
            if (s[3] && !prev_stb[3]) begin seq = {seq[11:0], 4'h3}; rises++; end
            if (s[2] && phy_bus != 16'h0) v_rdbus++;
            if ((s[1] || s[3]) && phy_bus != exp_data) v_data++;
            if (s != 4'b0 && phy_ack) ack_seen = 1'b1;
            if (s == 4'b0 && prev_stb != 4'b0 && !ack_seen && !err) v_drop++;
            if (s == 4'b0) ack_seen = 1'b0;
            if (s == 4'b0 && phy_bus == prev_bus) quiet++;
            else if (s == 4'b0) quiet = 1;
            else quiet = 0;
        end
        prev_stb = s;
        prev_bus = phy_bus;
    end

    // ---------------- watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic        t_done, t_err, t_busy0;
    logic [15:0] t_rdata;
    int          t_cyc;

    task automatic run_txn(input logic w, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        start = 1'b1; write_en = w; req_addr = a; req_wdata = d;
        exp_data = d;
        @(negedge clk);
        start = 1'b0;
        t_busy0 = busy;
        t_cyc = 1;
        while (!(done || err) && t_cyc < 2000) begin
            @(negedge clk);
            t_cyc++;
        end
        t_done = done; t_err = err; t_rdata = rdata;
    endtask

    // {write, addr, data, expected rdata}
    localparam logic [48:0] VEC [6] = '{
        {1'b1, 16'h0001, 16'h1234, 16'h0000},
        {1'b1, 16'h00A2, 16'hBEEF, 16'h0000},
        {1'b0, 16'h0001, 16'h0000, 16'h1234},
        {1'b0, 16'h00A2, 16'h0000, 16'hBEEF},
        {1'b1, 16'h0001, 16'hC3C3, 16'h0000},
        {1'b0, 16'h0001, 16'h0000, 16'hC3C3}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 done/err", {30'b0, done, err}, 0);
        chk("R1 strobes", {28'b0, phy_wr, phy_rd, phy_cap_data, phy_cap_addr}, 0);
        chk("R1 bus", {16'b0, phy_bus}, 0);
        chk("R1 rdata", {16'b0, rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int k = 0; k < 6; k++) begin
            ack_dly = k % 3;
            run_txn(VEC[k][48], VEC[k][47:32], VEC[k][31:16]);
            chk("R8 busy after start", {31'b0, t_busy0}, 1);
            chk("R8 done", {30'b0, t_done, t_err}, 2);
            if (VEC[k][48]) chk("R3 strobe order", {20'b0, seq[11:0]}, 32'h123);
            else begin
                chk("R2 address phase first", {24'b0, seq[7:0]}, 32'h14);
                chk("R4 read data", {16'b0, t_rdata}, {16'b0, VEC[k][15:0]});
            end
            @(negedge clk);
            chk("R8 busy low after done", {31'b0, busy}, 0);
        end
        chk("R2 address captured", {16'b0, lat_a}, 32'h0001);
        chk("R3 write data held on bus", v_data, 0);
        chk("R4 bus zero under read strobe", v_rdbus, 0);
        chk("R5 setup cycles before capture", v_setup, 0);
        chk("R6 single strobe", v_multi, 0);
        chk("R6 strobe held until ack", v_drop, 0);

        // R7 boundary: late ack inside the window passes
        ack_dly = 6;
        run_txn(1'b0, 16'h00A2, 16'h0);
        chk("R7 late ack within limit", {30'b0, t_done, t_err}, 2);
        chk("R7 late ack read data", {16'b0, t_rdata}, 32'hBEEF);

        // R7 boundary: ack beyond the window aborts, rdata forced to zero
        ack_dly = 20;
        run_txn(1'b0, 16'h0001, 16'h0);
        chk("R7 too-late ack aborts", {30'b0, t_done, t_err}, 1);
        chk("R7 abort rdata zero", {16'b0, t_rdata}, 0);
        repeat (30) @(negedge clk);
        ack_dly = 1;

        // R7 never acknowledged: exact abort cycle, idle and quiet afterwards
        ack_mode = 1;
        begin
            int r0;
            r0 = rises;
            run_txn(1'b0, 16'h0002, 16'h0);
            chk("R7 abort cycle", t_cyc, TO_CYC);
            chk("R7 err pulse", {30'b0, t_done, t_err}, 1);
            chk("R7 only address strobe raised", rises - r0, 1);
        end
        @(negedge clk);
        chk("R7 idle after abort", {31'b0, busy}, 0);
        chk("R7 strobes low after abort", {28'b0, phy_wr, phy_rd, phy_cap_data, phy_cap_addr}, 0);

        // R7 ack never released: wait-low phase times out
        ack_mode = 2;
        run_txn(1'b1, 16'h0005, 16'h7777);
        chk("R7 stuck ack aborts", {30'b0, t_done, t_err}, 1);
        ack_mode = 0;
        repeat (10) @(negedge clk);

        // R9 start while busy is ignored
        @(negedge clk);
        start = 1'b1; write_en = 1'b1; req_addr = 16'h0003; req_wdata = 16'h5555;
        exp_data = 16'h5555;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; req_addr = 16'h0004; req_wdata = 16'h6666;
        @(negedge clk);
        start = 1'b0;
        req_addr = '0; req_wdata = '0;
        t_cyc = 0;
        while (!done && t_cyc < 2000) begin @(negedge clk); t_cyc++; end
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 no second access", {31'b0, busy}, 0);
        run_txn(1'b0, 16'h0003, 16'h0);
        chk("R9 original data written", {16'b0, t_rdata}, 32'h5555);
        run_txn(1'b0, 16'h0004, 16'h0);
        chk("R9 ignored request left register", {16'b0, t_rdata}, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule